// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is a two-wire serial target that holds twenty 8-bit configuration registers for a host. It decodes its own device address, then serves four transfer types. Block write and block read use command code 0x00 and walk the register array from index 0 upward. Byte-data write and byte-data read use command code k+1 to reach register k. Every register is also presented on a wide parallel bus, so the surrounding logic reads its settings directly.

SCL and SDA are sampled with a two-flop synchroniser on the internal clock. SDA is driven open-drain through a single pull-low enable. The target never stretches SCL, so a host cannot be held off. The serial line is the only data path, and the power-good, power-down and strap pins are plain level controls. Each bit of a register has one access type: writable, read-only, latched from a strap pin, or set-only (sticky).

Top module: `smbcfg_top`

## Requirements
- R1: The target acknowledges only the 8-bit address bytes 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged, and the following bytes of that transfer change no register.
- R2: Block write is START, 0xD2, command 0x00, count n, then data bytes, which go to registers 0, 1, 2, ... in turn. A data byte is acknowledged and stored only while its index is below both n and twenty. Bytes past that point are not acknowledged.
- R3: Byte-data write with command c in 1..20 stores one data byte into register c-1. A command above 20 is not acknowledged.
- R4: Block read is START, 0xD2, 0x00, repeated START, 0xD3. It returns a count byte of 20, then registers 0, 1, 2, ... for as long as the host acknowledges.
- R5: Byte-data read is START, 0xD2, command c, repeated START, 0xD3. It returns register c-1.
- R6: After reset, registers 0..19 hold 01,83,FF,FF,FF,00,0C,04,0C,25,D0,7A,7A,10,04,0B,30,0B,00,30 (hex).
- R7: Register 7 always reads 0x04, and bits 7:4 of register 8 always read 0000, whatever is written.
- R8: Bit 4 of register 0 is sticky. Writing 1 sets it, writing 0 leaves it set, and only reset clears it.
- R9: While power-good is high and no capture has yet taken place, the strap pins are captured once: strap[2:0] into reg0[7:5], strap[4:3] into reg14[1:0], and strap[5] into reg9[6]. These bits read 0 before the capture. After it, neither writes nor strap changes alter them.
- R10: When power-down falls, bit 0 of register 0 decides what happens. If that bit is 1, every register is kept. If it is 0, every writable bit returns to its R6 value, while sticky and strap bits keep their state.
- R11: The SDA pull-down changes only while SCL is low. A START at any point, including in the middle of a byte, restarts address reception.
- R12: Writable bits are all bits except reg0[7:4], reg7[7:0], reg8[7:4], reg9[6] and reg14[1:0]. Writes to the non-writable bits are ignored, apart from the sticky set of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| pwr_good_i | input | 1 | Power-good level; its first high sample captures the straps |
| pd_i | input | 1 | Power-down level; the falling edge is the exit |
| strap_i | input | 6 | Strap pin levels |
| cfg_o | output | NREG*8 | All registers, register k in bits 8k+7:8k |

## Verification
The hardest state to reach from the pins is the exit from power-down with the restore bit cleared. At that point the sticky bit has already been set, the straps have already been captured, and every writable field has been moved away from its default. Only then does the exit show that the reload spares the sticky and strap bits. The bench builds this state in order. It captures the straps, sweeps byte-data writes over every register, and sets the sticky bit through a full block write. It then pulses power-down once with the restore bit set and once with it cleared. A START in the middle of a byte is forced by cutting a byte off after three bits.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  localparam int unsigned STRAP_W = 6;

  typedef enum logic [1:0] {K_ADDR, K_CMD, K_CNT, K_DATA} rx_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_SACK, ST_TX, ST_MACK} smb_st_e;

  function automatic logic [7:0] reg_default(int idx);
    case (idx)
      0: return 8'h01;   1: return 8'h83;   2: return 8'hFF;   3: return 8'hFF;
      4: return 8'hFF;   5: return 8'h00;   6: return 8'h0C;   7: return 8'h04;
      8: return 8'h0C;   9: return 8'h25;  10: return 8'hD0;  11: return 8'h7A;
      12: return 8'h7A; 13: return 8'h10;  14: return 8'h04;  15: return 8'h0B;
      16: return 8'h30; 17: return 8'h0B;  18: return 8'h00;  19: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  // bits a plain write may change
  function automatic logic [7:0] rw_mask(int idx);
    case (idx)
      0: return 8'h0F;
      7: return 8'h00;
      8: return 8'h0F;
      9: return 8'hBF;
      14: return 8'hFC;
      default: return 8'hFF;
    endcase
  endfunction

  // bits that can only be set by a write
  function automatic logic [7:0] sticky_mask(int idx);
    return (idx == 0) ? 8'h10 : 8'h00;
  endfunction

  // bits captured from straps
  function automatic logic [7:0] latch_mask(int idx);
    case (idx)
      0: return 8'hE0;
      9: return 8'h40;
      14: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] latch_value(int idx, logic [STRAP_W-1:0] s);
    case (idx)
      0: return {s[2:0], 5'b0};
      9: return {1'b0, s[5], 6'b0};
      14: return {6'b0, s[4:3]};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smbcfg_sync.sv
module smbcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign q_o    = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs
  import smbcfg_pkg::*;
#(
  parameter int NREG = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [7:0]           wr_idx_i,
  input  logic [7:0]           wr_data_i,
  input  logic [7:0]           rd_idx_i,
  output logic [7:0]           rd_data_o,
  input  logic                 pwr_good_i,
  input  logic                 pd_i,
  input  logic [STRAP_W-1:0]   strap_i,
  output logic                 strap_done_o,
  output logic [NREG*8-1:0]    cfg_o
);
  logic strap_done_q, pd_q;
  logic do_latch, pd_exit;

  assign do_latch     = pwr_good_i & ~strap_done_q;
  assign pd_exit      = pd_q & ~pd_i & ~cfg_o[0];
  assign strap_done_o = strap_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done_q <= 1'b0;
      pd_q         <= 1'b0;
    end else begin
      pd_q <= pd_i;
      if (do_latch) strap_done_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] DEF = reg_default(g);
    localparam logic [7:0] RW  = rw_mask(g);
    localparam logic [7:0] STK = sticky_mask(g);
    localparam logic [7:0] LAT = latch_mask(g);
    logic [7:0] q, d;

    always_comb begin
      d = q;
      if (pd_exit) d = (q & ~RW) | (DEF & RW);
      if (wr_en_i && wr_idx_i == 8'(g)) d = (d & ~RW) | (wr_data_i & RW) | (wr_data_i & STK);
      if (do_latch) d = (d & ~LAT) | (latch_value(g, strap_i) & LAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= DEF;
      else        q <= d;
    end

    assign cfg_o[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data_o = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx_i == 8'(i)) rd_data_o = cfg_o[i*8 +: 8];
  end
endmodule

// File: rtl/smbcfg_proto.sv
module smbcfg_proto
  import smbcfg_pkg::*;
#(
  parameter int          NREG     = 20,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_q_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_q_i,
  input  logic       sda_rise_i,
  input  logic       sda_fall_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_idx_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  localparam logic [7:0] NREG8 = 8'(NREG);

  smb_st_e    st_q;
  rx_kind_e   kind_q;
  logic [3:0] bcnt_q;
  logic [7:0] sh_q, tx_q, idx_q, lim_q;
  logic       blk_q, have_cmd_q, go_tx_q, cnt_pend_q, mack_q;
  logic       start_c, stop_c, acc;
  logic [7:0] ld;

  assign start_c  = sda_fall_i & scl_q_i;
  assign stop_c   = sda_rise_i & scl_q_i;
  assign rd_idx_o = idx_q;
  assign ld       = cnt_pend_q ? NREG8 : rd_data_i;

  always_comb begin
    acc = 1'b0;
    case (kind_q)
      K_ADDR: acc = (sh_q[7:1] == DEV_ADDR);
      K_CMD:  acc = (sh_q <= NREG8);
      K_CNT:  acc = 1'b1;
      K_DATA: acc = (idx_q < lim_q) && (idx_q < NREG8);
      default: acc = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  kind_q <= K_ADDR;  bcnt_q <= '0;
      sh_q <= '0;  tx_q <= '0;  idx_q <= '0;  lim_q <= '0;
      blk_q <= 1'b0;  have_cmd_q <= 1'b0;  go_tx_q <= 1'b0;
      cnt_pend_q <= 1'b0;  mack_q <= 1'b0;  sda_oe_o <= 1'b0;
      wr_en_o <= 1'b0;  wr_idx_o <= '0;  wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_c) begin
        st_q <= ST_RX;  kind_q <= K_ADDR;  bcnt_q <= '0;  sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        st_q <= ST_IDLE;  have_cmd_q <= 1'b0;  sda_oe_o <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (scl_rise_i && bcnt_q != 4'd8) begin
              sh_q   <= {sh_q[6:0], sda_q_i};
              bcnt_q <= bcnt_q + 4'd1;
            end
            if (scl_fall_i && bcnt_q == 4'd8) begin
              bcnt_q <= '0;
              if (!acc) begin
                st_q <= ST_IDLE;
              end else begin
                sda_oe_o <= 1'b1;
                st_q     <= ST_SACK;
                go_tx_q  <= 1'b0;
                case (kind_q)
                  K_ADDR: begin
                    if (sh_q[0]) begin
                      go_tx_q    <= 1'b1;
                      cnt_pend_q <= blk_q & have_cmd_q;
                    end else begin
                      kind_q <= K_CMD;
                    end
                  end
                  K_CMD: begin
                    have_cmd_q <= 1'b1;
                    if (sh_q == 8'h00) begin
                      blk_q <= 1'b1;  idx_q <= '0;  kind_q <= K_CNT;
                    end else begin
                      blk_q <= 1'b0;  idx_q <= sh_q - 8'd1;  lim_q <= sh_q;  kind_q <= K_DATA;
                    end
                  end
                  K_CNT: begin
                    lim_q  <= sh_q;
                    kind_q <= K_DATA;
                  end
                  default: begin
                    wr_en_o   <= 1'b1;
                    wr_idx_o  <= idx_q;
                    wr_data_o <= sh_q;
                    idx_q     <= idx_q + 8'd1;
                  end
                endcase
              end
            end
          end
          ST_SACK: begin
            if (scl_fall_i) begin
              if (go_tx_q) begin
                st_q <= ST_TX;  tx_q <= ld;  sda_oe_o <= ~ld[7];  bcnt_q <= 4'd1;
                if (cnt_pend_q) cnt_pend_q <= 1'b0;
                else            idx_q <= idx_q + 8'd1;
              end else begin
                st_q <= ST_RX;  sda_oe_o <= 1'b0;  bcnt_q <= '0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bcnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_MACK;
              end else begin
                sda_oe_o <= ~tx_q[6];
                tx_q     <= {tx_q[6:0], 1'b0};
                bcnt_q   <= bcnt_q + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) mack_q <= ~sda_q_i;
            if (scl_fall_i) begin
              if (mack_q) begin
                st_q <= ST_TX;  tx_q <= ld;  sda_oe_o <= ~ld[7];  bcnt_q <= 4'd1;
                if (cnt_pend_q) cnt_pend_q <= 1'b0;
                else            idx_q <= idx_q + 8'd1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbcfg_top.sv
module smbcfg_top
  import smbcfg_pkg::*;
#(
  parameter int         NREG        = 20,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               pwr_good_i,
  input  logic               pd_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [NREG*8-1:0]  cfg_o
);
  logic scl_q, scl_rise, scl_fall, sda_q, sda_rise, sda_fall;
  logic [7:0] rd_idx, rd_data, wr_idx, wr_data;
  logic wr_en, strap_done;

  smbcfg_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i),
    .q_o(scl_q), .rise_o(scl_rise), .fall_o(scl_fall));

  smbcfg_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i),
    .q_o(sda_q), .rise_o(sda_rise), .fall_o(sda_fall));

  smbcfg_proto #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_n),
    .scl_q_i(scl_q), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_q_i(sda_q), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .rd_data_i(rd_data), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o));

  smbcfg_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .pwr_good_i(pwr_good_i), .pd_i(pd_i), .strap_i(strap_i),
    .strap_done_o(strap_done), .cfg_o(cfg_o));
endmodule

// File: rtl/smbcfg_chk.sv
module smbcfg_chk #(
  parameter int NREG = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              strap_done,
  input logic [NREG*8-1:0] cfg_o
);
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i); // R11

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[4] |=> cfg_o[4]); // R8

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(cfg_o[7:5])); // R9

  if (NREG > 8) begin : g_ro
    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_o[63:56] == 8'h04); // R7

    AST_PKG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_o[71:68] == 4'h0); // R7
  end
endmodule

bind smbcfg_top smbcfg_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .strap_done(strap_done), .cfg_o(cfg_o));

// File: tb/smbcfg_top_tb_top.sv
module smbcfg_top_tb_top;
  localparam int NREG = 20;
  localparam int Q    = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, pg = 1'b0, pd = 1'b0;
  logic [5:0] strap = '0;
  logic sda_oe;
  logic [NREG*8-1:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  smbcfg_top #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .pwr_good_i(pg), .pd_i(pd), .strap_i(strap), .cfg_o(cfg));

  int checks = 0, fails = 0;
  logic [7:0] m  [NREG];
  logic [7:0] rb [NREG];
  logic       ab [NREG+2];

  function automatic logic [7:0] b_def(int k);
    logic [7:0] t [20] = '{8'h01,8'h83,8'hFF,8'hFF,8'hFF,8'h00,8'h0C,8'h04,8'h0C,8'h25,
                           8'hD0,8'h7A,8'h7A,8'h10,8'h04,8'h0B,8'h30,8'h0B,8'h00,8'h30};
    return t[k];
  endfunction
  function automatic logic [7:0] b_rw(int k);
    if (k == 0 || k == 8) return 8'h0F;
    if (k == 7) return 8'h00;
    if (k == 9) return 8'hBF;
    if (k == 14) return 8'hFC;
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mwr(input int k, input logic [7:0] v);
    if (k < NREG) m[k] = (m[k] & ~b_rw(k)) | (v & b_rw(k)) | ((k == 0) ? (v & 8'h10) : 8'h00);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NREG; k++) chk($sformatf("%s reg%0d", tag, k), 32'(cfg[k*8 +: 8]), 32'(m[k]));
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic bstart; sda_m = 1; wq; scl_m = 1; wq; sda_m = 0; wq; scl_m = 0; wq; endtask
  task automatic bstop;  sda_m = 0; wq; scl_m = 1; wq; sda_m = 1; wq; endtask
  task automatic wbit(input logic b); sda_m = b; wq; scl_m = 1; wq; wq; scl_m = 0; wq; endtask
  task automatic rbit(output logic b); sda_m = 1; wq; scl_m = 1; wq; b = sda_line; wq; scl_m = 0; wq; endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~ack);
  endtask

  task automatic byte_wr(input logic [7:0] dev, input logic [7:0] cmd, input logic [7:0] d,
                         output logic a0, output logic a1, output logic a2);
    bstart; wbyte(dev, a0); wbyte(cmd, a1); wbyte(d, a2); bstop; wq;
  endtask
  task automatic byte_rd(input logic [7:0] cmd, output logic [7:0] d);
    logic a;
    bstart; wbyte(8'hD2, a); wbyte(cmd, a); bstart; wbyte(8'hD3, a); rbyte(d, 1'b0); bstop; wq;
  endtask

  task automatic pulse_pd; pd = 1; repeat (5) @(negedge clk); pd = 0; repeat (5) @(negedge clk); endtask

  logic done = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] d, cnt;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    for (int k = 0; k < NREG; k++) m[k] = b_def(k);
    check_all("R6 reset");

    // R9: strap capture then freeze
    strap = 6'b1_10_101;
    pg = 1;
    repeat (4) @(negedge clk);
    m[0][7:5] = 3'b101; m[14][1:0] = 2'b10; m[9][6] = 1'b1;
    check_all("R9 capture");
    strap = 6'b0_01_010;
    repeat (4) @(negedge clk);
    check_all("R9 frozen");

    // R1: foreign addresses
    begin
      logic [7:0] bad [4] = '{8'hA0, 8'hD0, 8'hD4, 8'h52};
      for (int i = 0; i < 4; i++) begin
        byte_wr(bad[i], 8'h03, 8'h55, a0, a1, a2);
        chk("R1 foreign addr nack", 32'(a0), 32'd0);
      end
    end
    check_all("R1 no write");

    // R3 / R7 / R12: byte-data write sweep
    for (int k = 0; k < NREG; k++) begin
      logic [7:0] v = 8'((k * 37 + 5) & 255);
      byte_wr(8'hD2, 8'(k + 1), v, a0, a1, a2);
      chk($sformatf("R3 ack k%0d", k), 32'({a0, a1, a2}), 32'd7);
      mwr(k, v);
    end
    check_all("R3 R7 R12 sweep");
    byte_wr(8'hD2, 8'(NREG + 1), 8'h00, a0, a1, a2);
    chk("R3 cmd range nack", 32'(a1), 32'd0);
    check_all("R3 range no write");

    // R5: byte-data read of each register
    for (int k = 0; k < NREG; k++) begin
      byte_rd(8'(k + 1), d);
      chk($sformatf("R5 read k%0d", k), 32'(d), 32'(m[k]));
    end

    // R4: block read
    bstart; wbyte(8'hD2, a0); wbyte(8'h00, a1); bstart; wbyte(8'hD3, a2);
    rbyte(cnt, 1'b1);
    for (int i = 0; i < NREG; i++) rbyte(rb[i], i < NREG - 1);
    bstop; wq;
    chk("R4 count", 32'(cnt), 32'(NREG));
    for (int i = 0; i < NREG; i++) chk($sformatf("R4 data%0d", i), 32'(rb[i]), 32'(m[i]));

    // R2: block write, count 5, seven bytes offered
    bstart; wbyte(8'hD2, a0); wbyte(8'h00, a1); wbyte(8'd5, a2);
    for (int i = 0; i < 7; i++) wbyte(8'(8'hA0 + i), ab[i]);
    bstop; wq;
    for (int i = 0; i < 7; i++) chk($sformatf("R2 ack byte%0d", i), 32'(ab[i]), (i < 5) ? 32'd1 : 32'd0);
    for (int i = 0; i < 5; i++) mwr(i, 8'(8'hA0 + i));
    check_all("R2 short block");

    // R2 / R8: full block write, count 22, reg0 value sets sticky bit
    bstart; wbyte(8'hD2, a0); wbyte(8'h00, a1); wbyte(8'(NREG + 2), a2);
    for (int i = 0; i < NREG + 2; i++) wbyte(8'((i * 11 + 8'h31) & 255), ab[i]);
    bstop; wq;
    for (int i = 0; i < NREG + 2; i++) chk($sformatf("R2 full ack%0d", i), 32'(ab[i]), (i < NREG) ? 32'd1 : 32'd0);
    for (int i = 0; i < NREG; i++) mwr(i, 8'((i * 11 + 8'h31) & 255));
    check_all("R2 full block");

    // R8: writing 0 does not clear the sticky bit
    byte_wr(8'hD2, 8'h01, 8'h01, a0, a1, a2);
    mwr(0, 8'h01);
    chk("R8 sticky held", 32'(cfg[4]), 32'd1);
    check_all("R8 after clear try");

    // R10: keep through power-down
    byte_wr(8'hD2, 8'h03, 8'h5A, a0, a1, a2);
    mwr(2, 8'h5A);
    pulse_pd;
    check_all("R10 keep");
    // R10: restore on exit
    byte_wr(8'hD2, 8'h01, 8'h00, a0, a1, a2);
    mwr(0, 8'h00);
    byte_wr(8'hD2, 8'h03, 8'h12, a0, a1, a2);
    mwr(2, 8'h12);
    pulse_pd;
    for (int k = 0; k < NREG; k++) m[k] = (m[k] & ~b_rw(k)) | (b_def(k) & b_rw(k));
    check_all("R10 restore");

    // R11: START in the middle of a byte restarts address phase
    bstart; wbyte(8'hD2, a0); wbit(1'b0); wbit(1'b1); wbit(1'b1);
    byte_rd(8'd14, d);
    chk("R11 restart read", 32'(d), 32'(m[13]));
    check_all("R11 no stray write");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule